// File: doc/BRIEF.md
# Serial Register Access Slave (24-bit frames)

This block lets an external serial master read and write a bank of 16-bit registers. Each transfer is one frame of exactly 24 serial clocks, framed by an active-low chip select. The first eight bits form a command byte: a direction flag, then a 7-bit register number. The remaining sixteen bits carry a data word. Every field is sent most significant bit first. The slave samples its serial input on rising serial-clock edges and changes its serial output on falling edges. The serial clock may rest either low or high between frames.

Chip select, serial clock and serial input pass through two-flop synchronizers into the system clock domain, and edges are detected there. The system clock must run at least four times faster than the serial clock. A write is carried out only when chip select rises after all 24 rising edges have arrived. Raising chip select any earlier drops the frame. For a read, the bank is sampled right after the command byte, and the word goes out on the serial output while the data bits are clocked.

The control is a four-state machine:
- `ST_IDLE`: waits for chip select to fall, which moves it to `ST_CMD`.
- `ST_CMD`: collects the command byte. After the 8th rising edge it moves to `ST_DATA`. A chip-select rise returns it to `ST_IDLE`.
- `ST_DATA`: collects or sends the data word. After the 24th rising edge it moves to `ST_DONE`. A chip-select rise returns it to `ST_IDLE` and drops the frame.
- `ST_DONE`: ignores further serial clocks. A chip-select rise returns it to `ST_IDLE` and, for a write frame, issues the write strobe.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `reg_we`, `reg_re` and `spi_miso_oe` are all low.
- R2: The first bit of a frame is the direction flag (1 = read, 0 = write). The next 7 bits are the register address, MSB first. The last 16 bits are the data word, MSB first.
- R3: For a write frame with 24 rising edges, the chip-select rise produces exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` holds the frame's address and `reg_wdata` holds its data word.
- R4: If chip select rises before the 24th rising edge of a write frame, no `reg_we` pulse occurs.
- R5: In a read frame, one `reg_re` pulse occurs after the 8th rising edge, with `reg_addr` holding the address. `reg_rdata` is taken in that same cycle. The word is then driven on `spi_miso`, MSB first, one bit per falling edge, starting at the falling edge that follows the 8th rising edge.
- R6: `spi_miso_oe` is high only during the data phase of a read frame, until chip select rises. During write frames it stays low.
- R7: If chip select rises in the middle of a read, `spi_miso_oe` drops within four system clocks. The next frame then works normally.
- R8: Serial clocks after the 24th within one frame have no effect: the word written is the first 16 data bits.
- R9: Frames behave the same whether the serial clock rests low or high.
- R10: Read frames never produce `reg_we`, and write frames never produce `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (valid while `spi_miso_oe` is high) |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| reg_addr | output | 7 | Register address of the current frame |
| reg_wdata | output | 16 | Write data, valid with `reg_we` |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Read data, sampled in the cycle `reg_re` is high |

## Verification
The bench uses the default parameters: a 7-bit address, a 16-bit data word and two synchronizer stages. It runs the serial clock sixteen times slower than the system clock. With those values, every bit of a full frame, aborted frames at several bit counts, overlong frames and both rest levels of the serial clock can all be driven in a few thousand cycles. The bank model returns an address-dependent word, so a swapped bit order or wrong address shows up directly in the read data.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= level;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_edge
            assign rise[g] =  level[g] & ~prev[g];
            assign fall[g] = ~level[g] &  prev[g];
        end
    endgenerate
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             bit_out
);
    logic [WIDTH-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            bit_out <= 1'b0;
        end else if (clear) begin
            word_q  <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            word_q  <= din;
        end else if (shift) begin
            bit_out <= word_q[WIDTH-1];
            word_q  <= {word_q[WIDTH-2:0], 1'b0};
        end
    end

    AST_LOAD_SHIFT_APART: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !shift) else $error("load and shift collided"); // R5
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CMD_W   = ADDR_W + 1;
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);

    // synchronized pins: {cs_n, sck, mosi}
    logic [2:0] pins_s;
    logic [1:0] rise_v, fall_v;
    logic       cs_rise, cs_fall, sck_rise, sck_fall, mosi_s;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s)
    );

    spi_edge_det #(.WIDTH(2), .RST_VAL(2'b10)) u_edges (
        .clk(clk), .rst_n(rst_n), .level(pins_s[2:1]),
        .rise(rise_v), .fall(fall_v)
    );

    assign cs_rise  = rise_v[1];
    assign cs_fall  = fall_v[1];
    assign sck_rise = rise_v[0];
    assign sck_fall = fall_v[0];
    assign mosi_s   = pins_s[0];

    frame_state_t      state, state_nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] rx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [CMD_W-1:0]  cmd_nxt;
    logic              tx_bit;

    assign cmd_nxt = {rx_q[CMD_W-2:0], mosi_s};

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (cs_fall) state_nxt = ST_CMD;
            ST_CMD: begin
                if (cs_rise)                                state_nxt = ST_IDLE;
                else if (sck_rise && bitcnt == CMD_LAST)    state_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (cs_rise)                                state_nxt = ST_IDLE;
                else if (sck_rise && bitcnt == FRAME_LAST)  state_nxt = ST_DONE;
            end
            ST_DONE: if (cs_rise) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            rx_q   <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            reg_we <= 1'b0;
            reg_re <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        bitcnt <= '0;
                        rd_q   <= 1'b0;
                    end
                end
                ST_CMD, ST_DATA: begin
                    if (sck_rise && !cs_rise) begin
                        rx_q   <= {rx_q[DATA_W-2:0], mosi_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (state == ST_CMD && bitcnt == CMD_LAST) begin
                            rd_q   <= cmd_nxt[CMD_W-1];
                            addr_q <= cmd_nxt[ADDR_W-1:0];
                            reg_re <= cmd_nxt[CMD_W-1];
                        end
                    end
                end
                ST_DONE: begin
                    if (cs_rise && !rd_q) reg_we <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    spi_tx_shift #(.WIDTH(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_IDLE && cs_fall),
        .load(reg_re),
        .shift(sck_fall && state == ST_DATA && rd_q),
        .din(reg_rdata),
        .bit_out(tx_bit)
    );

    assign reg_addr    = addr_q;
    assign reg_wdata   = rx_q;
    assign spi_miso_oe = rd_q && (state == ST_DATA || state == ST_DONE);
    assign spi_miso    = spi_miso_oe ? tx_bit : 1'b0;

    AST_WE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(state) == ST_DONE && !$past(rd_q))) else $error("write without full frame"); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we) else $error("write strobe longer than one cycle"); // R3
    AST_RE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> !reg_we) else $error("read and write strobes together"); // R10
    AST_RE_AT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (state == ST_DATA && $past(state) == ST_CMD)) else $error("read strobe outside command end"); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_W'(FRAME_W)) else $error("bit counter ran past frame"); // R8
endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [6:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we, reg_re;

    int checks = 0;
    int fails  = 0;
    logic [22:0] exp_wr_q[$];
    logic [6:0]  exp_rd_q[$];
    logic        oe_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] bank_val(input logic [6:0] a);
        return {a, ~a, 2'b10};
    endfunction

    assign reg_rdata = bank_val(reg_addr);

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor: pops expected strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_wr_q.size() == 0) check(1'b0, "R4/R10 unexpected write", {9'd0, reg_addr, reg_wdata}, 32'd0);
                else begin
                    logic [22:0] e;
                    e = exp_wr_q.pop_front();
                    check({reg_addr, reg_wdata} == e, "R3 write addr/data", {9'd0, reg_addr, reg_wdata}, {9'd0, e});
                end
            end
            if (reg_re) begin
                if (exp_rd_q.size() == 0) check(1'b0, "R10 unexpected read", {25'd0, reg_addr}, 32'd0);
                else begin
                    logic [6:0] a;
                    a = exp_rd_q.pop_front();
                    check(reg_addr == a, "R5 read addr", {25'd0, reg_addr}, {25'd0, a});
                end
            end
        end
    end

    // driver: one frame of nbits serial clocks
    task automatic spi_xfer(input logic [23:0] word, input int nbits, input bit idle_hi, output logic [15:0] rd);
        rd = '0;
        oe_mid = 1'b0;
        spi_sck = idle_hi;
        #(CLK_PERIOD*4);
        spi_cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 24) ? word[23-i] : 1'b1;
            #(HALF);
            if (i >= 8 && i < 24) rd[23-i] = spi_miso;
            if (i == 12) oe_mid = spi_miso_oe;
            spi_sck = 1'b1;
            #(HALF);
        end
        if (!idle_hi) spi_sck = 1'b0;
        #(HALF);
        spi_cs_n = 1'b1;
        #(CLK_PERIOD*12);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d, input int nbits, input bit idle_hi, input string req);
        logic [15:0] rd;
        if (nbits >= 24) exp_wr_q.push_back({a, d});
        spi_xfer({1'b0, a, d}, nbits, idle_hi, rd);
        check(exp_wr_q.size() == 0, req, exp_wr_q.size(), 0);
        check(oe_mid == 1'b0, "R6 oe low in write", {31'd0, oe_mid}, 0);
    endtask

    task automatic do_read(input logic [6:0] a, input bit idle_hi, input string req);
        logic [15:0] rd;
        exp_rd_q.push_back(a);
        spi_xfer({1'b1, a, 16'h0000}, 24, idle_hi, rd);
        check(rd == bank_val(a), req, {16'd0, rd}, {16'd0, bank_val(a)});
        check(oe_mid == 1'b1, "R6 oe high in read data phase", {31'd0, oe_mid}, 1);
        check(spi_miso_oe == 1'b0, "R6 oe low after frame", {31'd0, spi_miso_oe}, 0);
        check(exp_rd_q.size() == 0, "R5 read strobe seen", exp_rd_q.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        #3;
        #(CLK_PERIOD*5);
        check(reg_we == 1'b0, "R1 we at reset", {31'd0, reg_we}, 0);
        check(reg_re == 1'b0, "R1 re at reset", {31'd0, reg_re}, 0);
        check(spi_miso_oe == 1'b0, "R1 oe at reset", {31'd0, spi_miso_oe}, 0);
        rst_n = 1'b1;
        #(CLK_PERIOD*5);
        check(spi_miso_oe == 1'b0 && reg_we == 1'b0, "R1 idle after reset", {30'd0, spi_miso_oe, reg_we}, 0);

        do_write(7'h15, 16'hBEEF, 24, 1'b0, "R2/R3 write frame");
        do_write(7'h6A, 16'h1234, 24, 1'b1, "R9 write with sck resting high");
        do_write(7'h01, 16'h8001, 27, 1'b0, "R8 extra clocks ignored");
        do_write(7'h33, 16'hFFFF, 20, 1'b0, "R4 abort after 20 clocks");
        do_write(7'h34, 16'hAAAA, 23, 1'b0, "R4 abort after 23 clocks");
        do_write(7'h35, 16'h5555, 3, 1'b0, "R4 abort in command byte");

        do_read(7'h2A, 1'b0, "R2/R5 read data MSB first");
        do_read(7'h7F, 1'b1, "R9 read with sck resting high");
        do_read(7'h00, 1'b0, "R5 read address zero");

        // aborted read: oe must drop soon after cs rises
        exp_rd_q.push_back(7'h51);
        spi_sck = 1'b0;
        #(CLK_PERIOD*4);
        spi_cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < 12; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 8) ? ((8'hD1 >> (7 - i)) & 8'h01) != 0 : 1'b0;
            #(HALF);
            spi_sck = 1'b1;
            #(HALF);
        end
        check(spi_miso_oe == 1'b1, "R7 oe high before abort", {31'd0, spi_miso_oe}, 1);
        spi_cs_n = 1'b1;
        #(CLK_PERIOD*4);
        check(spi_miso_oe == 1'b0, "R7 oe low after aborted read", {31'd0, spi_miso_oe}, 0);
        #(CLK_PERIOD*8);
        spi_sck = 1'b0;
        do_write(7'h44, 16'hC0DE, 24, 1'b0, "R7 write after aborted read");
        do_read(7'h44, 1'b0, "R7 read after aborted read");

        #(CLK_PERIOD*20);
        check(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, "R10 no stray strobes", exp_wr_q.size() + exp_rd_q.size(), 0);
        finish_run();
    end
endmodule